// File: doc/BRIEF.md
# Banked 20-bit Effective Address Generator

This block forms effective addresses for a 16-bit processor whose address space is 20 bits wide. Every 16-bit pointer (the three index registers X, Y and Z, and the program counter) carries a 4-bit bank field above it. Each mode adds its offset across the whole 20-bit bank:pointer concatenation. A carry or borrow out of the low 16 bits therefore moves into the bank field, and every sum wraps modulo 2^20.

On each clock edge the generator samples a mode code, an index select, a 24-bit instruction operand field, the three index pointers with their banks, the data bank field, the 16-bit E accumulator, the program counter with its bank, and a branch-taken flag. It registers the resulting address, a valid flag and an index-select error flag.

The post-modified mode uses bank:X as the address. When a strobe accompanies it, the block also registers the updated X pair for the datapath to write back.

Top module: `bank_addr_gen`

## Requirements
- R1: While `rst` is high, every output is held at zero. After reset, each output is registered and shows the result of the inputs sampled at the previous rising edge.
- R2: Mode 1 (extended): `ea = {ek, operand[15:0]}` with `ea_valid` high.
- R3: Mode 2 (long extended): `ea = operand[19:0]` with `ea_valid` high. `operand[23:20]` has no effect on `ea`.
- R4: Mode 3 (short indexed): `ea = {bank, ptr} + zero-extended operand[7:0]` modulo 2^20. The pointer is chosen by `idx_sel`: 0 = X/`xk`, 1 = Y/`yk`, 2 = Z/`zk`. Carries propagate into the bank.
- R5: Mode 4 (word indexed): `ea = {bank, ptr} + sign-extended operand[15:0]` modulo 2^20. Borrows propagate into the bank.
- R6: Mode 5 (long indexed): `ea = {bank, ptr} + operand[19:0]` modulo 2^20.
- R7: Mode 6 (accumulator indexed): `ea = {bank, ptr} + sign-extended acc_e` modulo 2^20.
- R8: Mode 7 (short relative) adds sign-extended `operand[7:0]` to `{pk, pc}`. Mode 8 (word relative) adds sign-extended `operand[15:0]`. `ea_valid` is high only when `br_taken` is high. When `br_taken` is low, `ea_valid` is low and `ea` is 0.
- R9: Mode 9 (post-modified X): `ea = {xk, ix}` with `ea_valid` high. When `wb_strobe` is also high, on that same edge `{xk_next, ix_next}` becomes `{xk, ix} + sign-extended operand[7:0]` modulo 2^20, and `wb_valid` goes high for that cycle.
- R10: Without mode 9 and `wb_strobe` together, `wb_valid` is low and `{xk_next, ix_next}` keeps its previous value.
- R11: In modes 3 to 6, `idx_sel` = 3 sets `idx_err` high, `ea_valid` low and `ea` to 0. In every other case `idx_err` is low.
- R12: Mode 0 (inherent) and the unused codes 10 to 15 give `ea_valid` low and `ea` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Addressing mode code |
| idx_sel | input | 2 | Index pointer select |
| operand | input | 24 | Instruction operand field |
| ix | input | 16 | Index pointer X |
| iy | input | 16 | Index pointer Y |
| iz | input | 16 | Index pointer Z |
| xk | input | 4 | Bank of X |
| yk | input | 4 | Bank of Y |
| zk | input | 4 | Bank of Z |
| ek | input | 4 | Data bank for extended mode |
| acc_e | input | 16 | E accumulator |
| pc | input | 16 | Program counter |
| pk | input | 4 | Bank of program counter |
| br_taken | input | 1 | Branch condition is satisfied |
| wb_strobe | input | 1 | Enables the post-modify writeback |
| ea | output | 20 | Registered effective address |
| ea_valid | output | 1 | The address is a valid memory address |
| idx_err | output | 1 | Illegal index select was used |
| wb_valid | output | 1 | A writeback value was loaded this cycle |
| ix_next | output | 16 | Updated X pointer |
| xk_next | output | 4 | Updated X bank |

## Verification
The bench builds the block with its default widths: 16-bit pointers and 4-bit banks. With these widths, pointer values close to 0xFFFF and 0x0000 make carries into the bank and borrows out of it easy to produce. Bank value 0xF makes a wrap at 2^20 easy to produce. Directed cases cover these points, the illegal select, an untaken branch and a post-modify without strobe. Random cases over all 16 mode codes then cover the remaining input combinations.

// File: rtl/bam_pkg.sv
package bam_pkg;
  localparam logic [3:0] AM_INH   = 4'd0;
  localparam logic [3:0] AM_EXT   = 4'd1;
  localparam logic [3:0] AM_EXT20 = 4'd2;
  localparam logic [3:0] AM_IDX8  = 4'd3;
  localparam logic [3:0] AM_IDX16 = 4'd4;
  localparam logic [3:0] AM_IDX20 = 4'd5;
  localparam logic [3:0] AM_ACCE  = 4'd6;
  localparam logic [3:0] AM_REL8  = 4'd7;
  localparam logic [3:0] AM_REL16 = 4'd8;
  localparam logic [3:0] AM_POSTX = 4'd9;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_DIRECT,
    SRC_INDEX,
    SRC_PC,
    SRC_XPTR
  } src_e;
endpackage

// File: rtl/bam_base_sel.sv
module bam_base_sel #(
  parameter int WORD_W  = 16,
  parameter int BANK_W  = 4,
  parameter int NUM_PTR = 3,
  parameter int SEL_W   = 2
) (
  input  logic [SEL_W-1:0]                  sel,
  input  logic [NUM_PTR-1:0][WORD_W-1:0]    words,
  input  logic [NUM_PTR-1:0][BANK_W-1:0]    banks,
  output logic [WORD_W+BANK_W-1:0]          base,
  output logic                              sel_bad
);
  localparam int ADDR_W = WORD_W + BANK_W;

  logic [NUM_PTR-1:0][ADDR_W-1:0] joined;

  genvar g;
  generate
    for (g = 0; g < NUM_PTR; g++) begin : g_join
      assign joined[g] = {banks[g], words[g]};
    end
  endgenerate

  always_comb begin
    base    = '0;
    sel_bad = 1'b1;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (int'(sel) == i) begin
        base    = joined[i];
        sel_bad = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bam_offset_gen.sv
module bam_offset_gen
  import bam_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int BANK_W  = 4,
  parameter int SHORT_W = 8,
  parameter int OPER_W  = 24
) (
  input  logic [3:0]                 mode,
  input  logic [OPER_W-1:0]          operand,
  input  logic [WORD_W-1:0]          acc_e,
  input  logic [BANK_W-1:0]          ek,
  input  logic                       br_taken,
  output src_e                       src,
  output logic [WORD_W+BANK_W-1:0]   direct,
  output logic [WORD_W+BANK_W-1:0]   offset
);
  localparam int ADDR_W = WORD_W + BANK_W;

  logic [ADDR_W-1:0] short_zx, short_sx, word_sx, acc_sx;

  assign short_zx = {{(ADDR_W-SHORT_W){1'b0}}, operand[SHORT_W-1:0]};
  assign short_sx = {{(ADDR_W-SHORT_W){operand[SHORT_W-1]}}, operand[SHORT_W-1:0]};
  assign word_sx  = {{BANK_W{operand[WORD_W-1]}}, operand[WORD_W-1:0]};
  assign acc_sx   = {{BANK_W{acc_e[WORD_W-1]}}, acc_e};

  always_comb begin
    src    = SRC_NONE;
    direct = '0;
    offset = '0;
    case (mode)
      AM_EXT:   begin src = SRC_DIRECT; direct = {ek, operand[WORD_W-1:0]}; end
      AM_EXT20: begin src = SRC_DIRECT; direct = operand[ADDR_W-1:0]; end
      AM_IDX8:  begin src = SRC_INDEX;  offset = short_zx; end
      AM_IDX16: begin src = SRC_INDEX;  offset = word_sx; end
      AM_IDX20: begin src = SRC_INDEX;  offset = operand[ADDR_W-1:0]; end
      AM_ACCE:  begin src = SRC_INDEX;  offset = acc_sx; end
      AM_REL8:  begin src = br_taken ? SRC_PC : SRC_NONE; offset = short_sx; end
      AM_REL16: begin src = br_taken ? SRC_PC : SRC_NONE; offset = word_sx; end
      AM_POSTX: begin src = SRC_XPTR; end
      default:  begin src = SRC_NONE; end
    endcase
  end
endmodule

// File: rtl/bam_add.sv
module bam_add #(
  parameter int W = 20
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  assign sum = a + b;
endmodule

// File: rtl/bam_wb_reg.sv
module bam_wb_reg #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         loaded
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      loaded <= 1'b0;
    end else begin
      loaded <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import bam_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int BANK_W  = 4,
  parameter int SHORT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [3:0]                mode,
  input  logic [1:0]                idx_sel,
  input  logic [((WORD_W+BANK_W+7)/8)*8-1:0] operand,
  input  logic [WORD_W-1:0]         ix,
  input  logic [WORD_W-1:0]         iy,
  input  logic [WORD_W-1:0]         iz,
  input  logic [BANK_W-1:0]         xk,
  input  logic [BANK_W-1:0]         yk,
  input  logic [BANK_W-1:0]         zk,
  input  logic [BANK_W-1:0]         ek,
  input  logic [WORD_W-1:0]         acc_e,
  input  logic [WORD_W-1:0]         pc,
  input  logic [BANK_W-1:0]         pk,
  input  logic                      br_taken,
  input  logic                      wb_strobe,
  output logic [WORD_W+BANK_W-1:0]  ea,
  output logic                      ea_valid,
  output logic                      idx_err,
  output logic                      wb_valid,
  output logic [WORD_W-1:0]         ix_next,
  output logic [BANK_W-1:0]         xk_next
);
  localparam int ADDR_W  = WORD_W + BANK_W;
  localparam int OPER_W  = ((ADDR_W + 7) / 8) * 8;
  localparam int NUM_PTR = 3;

  src_e              src;
  logic [ADDR_W-1:0] direct, offset, idx_base, base, sum_ea;
  logic [ADDR_W-1:0] x_pair, x_step, x_sum;
  logic              sel_bad, bad_idx, good;
  logic              unused_hi;

  assign unused_hi = ^operand[OPER_W-1:ADDR_W];

  bam_offset_gen #(.WORD_W(WORD_W), .BANK_W(BANK_W), .SHORT_W(SHORT_W), .OPER_W(OPER_W)) u_off (
    .mode(mode), .operand(operand), .acc_e(acc_e), .ek(ek), .br_taken(br_taken),
    .src(src), .direct(direct), .offset(offset)
  );

  bam_base_sel #(.WORD_W(WORD_W), .BANK_W(BANK_W), .NUM_PTR(NUM_PTR), .SEL_W(2)) u_sel (
    .sel(idx_sel), .words({iz, iy, ix}), .banks({zk, yk, xk}),
    .base(idx_base), .sel_bad(sel_bad)
  );

  assign x_pair = {xk, ix};

  always_comb begin
    case (src)
      SRC_DIRECT: base = direct;
      SRC_INDEX:  base = idx_base;
      SRC_PC:     base = {pk, pc};
      SRC_XPTR:   base = x_pair;
      default:    base = '0;
    endcase
  end

  bam_add #(.W(ADDR_W)) u_ea_add (.a(base), .b(offset), .sum(sum_ea));

  assign bad_idx = (src == SRC_INDEX) && sel_bad;
  assign good    = (src != SRC_NONE) && !bad_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ea       <= '0;
      ea_valid <= 1'b0;
      idx_err  <= 1'b0;
    end else begin
      ea       <= good ? sum_ea : '0;
      ea_valid <= good;
      idx_err  <= bad_idx;
    end
  end

  assign x_step = {{(ADDR_W-SHORT_W){operand[SHORT_W-1]}}, operand[SHORT_W-1:0]};

  bam_add #(.W(ADDR_W)) u_wb_add (.a(x_pair), .b(x_step), .sum(x_sum));

  logic [ADDR_W-1:0] wb_q;

  bam_wb_reg #(.W(ADDR_W)) u_wb (
    .clk(clk), .rst(rst), .load((mode == AM_POSTX) && wb_strobe),
    .d(x_sum), .q(wb_q), .loaded(wb_valid)
  );

  assign ix_next = wb_q[WORD_W-1:0];
  assign xk_next = wb_q[ADDR_W-1:WORD_W];
endmodule

// File: rtl/bam_checker.sv
module bam_checker
  import bam_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int BANK_W  = 4,
  parameter int SHORT_W = 8,
  parameter int OPER_W  = 24
) (
  input logic                      clk,
  input logic                      rst,
  input logic [3:0]                mode,
  input logic [1:0]                idx_sel,
  input logic [OPER_W-1:0]         operand,
  input logic [WORD_W-1:0]         ix,
  input logic [BANK_W-1:0]         xk,
  input logic [BANK_W-1:0]         ek,
  input logic                      br_taken,
  input logic                      wb_strobe,
  input logic [WORD_W+BANK_W-1:0]  ea,
  input logic                      ea_valid,
  input logic                      idx_err,
  input logic                      wb_valid,
  input logic [WORD_W-1:0]         ix_next,
  input logic [BANK_W-1:0]         xk_next
);
  localparam int ADDR_W = WORD_W + BANK_W;

  logic uses_idx;
  assign uses_idx = (mode >= AM_IDX8) && (mode <= AM_ACCE);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ea == '0) && !ea_valid && !idx_err && !wb_valid);

  assert_ext_concat_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == AM_EXT) |=> ea_valid && (ea == {$past(ek), $past(operand[WORD_W-1:0])}));

  assert_ext20_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == AM_EXT20) |=> ea_valid && (ea == $past(operand[ADDR_W-1:0])));

  assert_rel_untaken_R8: assert property (@(posedge clk) disable iff (rst)
    (((mode == AM_REL8) || (mode == AM_REL16)) && !br_taken) |=> !ea_valid && (ea == '0));

  assert_postx_ea_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == AM_POSTX) |=> ea_valid && (ea == {$past(xk), $past(ix)}));

  assert_wb_update_R9: assert property (@(posedge clk) disable iff (rst)
    ((mode == AM_POSTX) && wb_strobe) |=> wb_valid &&
      ({xk_next, ix_next} == ADDR_W'($past({xk, ix}) +
        {{(ADDR_W-SHORT_W){$past(operand[SHORT_W-1])}}, $past(operand[SHORT_W-1:0])})));

  assert_wb_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !((mode == AM_POSTX) && wb_strobe) |=> !wb_valid && $stable({xk_next, ix_next}));

  assert_bad_sel_R11: assert property (@(posedge clk) disable iff (rst)
    (uses_idx && (idx_sel == 2'd3)) |=> idx_err && !ea_valid);

  assert_no_err_R11: assert property (@(posedge clk) disable iff (rst)
    !(uses_idx && (idx_sel == 2'd3)) |=> !idx_err);

  assert_inherent_idle_R12: assert property (@(posedge clk) disable iff (rst)
    ((mode == AM_INH) || (mode > AM_POSTX)) |=> !ea_valid && (ea == '0));
endmodule

bind bank_addr_gen bam_checker #(
  .WORD_W(WORD_W), .BANK_W(BANK_W), .SHORT_W(SHORT_W), .OPER_W(OPER_W)
) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .idx_sel(idx_sel), .operand(operand),
  .ix(ix), .xk(xk), .ek(ek), .br_taken(br_taken), .wb_strobe(wb_strobe),
  .ea(ea), .ea_valid(ea_valid), .idx_err(idx_err), .wb_valid(wb_valid),
  .ix_next(ix_next), .xk_next(xk_next)
);

// File: tb/bank_addr_gen_test.sv
`timescale 1ns/1ps
module bank_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  mode;
  logic [1:0]  idx_sel;
  logic [23:0] operand;
  logic [15:0] ix, iy, iz, acc_e, pc;
  logic [3:0]  xk, yk, zk, ek, pk;
  logic        br_taken, wb_strobe;
  logic [19:0] ea;
  logic        ea_valid, idx_err, wb_valid;
  logic [15:0] ix_next;
  logic [3:0]  xk_next;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [19:0] wb_model = '0;

  always #2.5 clk = ~clk;

  bank_addr_gen uut (
    .clk(clk), .rst(rst), .mode(mode), .idx_sel(idx_sel), .operand(operand),
    .ix(ix), .iy(iy), .iz(iz), .xk(xk), .yk(yk), .zk(zk), .ek(ek),
    .acc_e(acc_e), .pc(pc), .pk(pk), .br_taken(br_taken), .wb_strobe(wb_strobe),
    .ea(ea), .ea_valid(ea_valid), .idx_err(idx_err), .wb_valid(wb_valid),
    .ix_next(ix_next), .xk_next(xk_next)
  );

  function automatic string req_for(input logic [3:0] m);
    case (m)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7, 4'd8: return "R8";
      4'd9: return "R9";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [19:0] sx8(input logic [7:0] v);
    return {{12{v[7]}}, v};
  endfunction

  function automatic logic [19:0] sx16(input logic [15:0] v);
    return {{4{v[15]}}, v};
  endfunction

  task automatic model(output logic [19:0] e, output logic v, output logic er);
    logic [19:0] b;
    logic idxm;
    idxm = (mode >= 4'd3) && (mode <= 4'd6);
    case (idx_sel)
      2'd0: b = {xk, ix};
      2'd1: b = {yk, iy};
      2'd2: b = {zk, iz};
      default: b = 20'h0;
    endcase
    e = 20'h0; v = 1'b0; er = 1'b0;
    if (idxm && idx_sel == 2'd3) begin
      er = 1'b1;
    end else begin
      case (mode)
        4'd1: begin e = {ek, operand[15:0]}; v = 1'b1; end
        4'd2: begin e = operand[19:0]; v = 1'b1; end
        4'd3: begin e = b + {12'h0, operand[7:0]}; v = 1'b1; end
        4'd4: begin e = b + sx16(operand[15:0]); v = 1'b1; end
        4'd5: begin e = b + operand[19:0]; v = 1'b1; end
        4'd6: begin e = b + sx16(acc_e); v = 1'b1; end
        4'd7: if (br_taken) begin e = {pk, pc} + sx8(operand[7:0]); v = 1'b1; end
        4'd8: if (br_taken) begin e = {pk, pc} + sx16(operand[15:0]); v = 1'b1; end
        4'd9: begin e = {xk, ix}; v = 1'b1; end
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string req, input string what, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step();
    logic [19:0] e;
    logic v, er, wbv;
    string r;
    model(e, v, er);
    wbv = (mode == 4'd9) && wb_strobe;
    if (wbv) wb_model = {xk, ix} + sx8(operand[7:0]);
    r = (er ? "R11" : req_for(mode));
    @(negedge clk);
    chk(r, "ea", ea, e);
    chk(r, "ea_valid", {19'h0, ea_valid}, {19'h0, v});
    chk("R11", "idx_err", {19'h0, idx_err}, {19'h0, er});
    chk(wbv ? "R9" : "R10", "wb_valid", {19'h0, wb_valid}, {19'h0, wbv});
    chk(wbv ? "R9" : "R10", "wb pair", {xk_next, ix_next}, wb_model);
  endtask

  task automatic clear_inputs();
    mode = 4'd0; idx_sel = 2'd0; operand = '0;
    ix = '0; iy = '0; iz = '0; xk = '0; yk = '0; zk = '0; ek = '0;
    acc_e = '0; pc = '0; pk = '0; br_taken = 1'b0; wb_strobe = 1'b0;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst = 1'b1;
    clear_inputs();
    mode = 4'd1; ek = 4'hF; operand = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    chk("R1", "ea in reset", ea, 20'h0);
    chk("R1", "flags in reset", {16'h0, ea_valid, idx_err, wb_valid, 1'b0}, 20'h0);
    chk("R1", "wb pair in reset", {xk_next, ix_next}, 20'h0);
    clear_inputs();
    rst = 1'b0;

    // R2 extended concat
    mode = 4'd1; ek = 4'hA; operand = 24'h551234; step();
    // R3 top nibble ignored
    mode = 4'd2; operand = 24'hFABCDE; step();
    // R4 carry into bank via X
    mode = 4'd3; idx_sel = 2'd0; xk = 4'h3; ix = 16'hFFF0; operand = 24'h000020; step();
    // R5 borrow out of bank via Y
    mode = 4'd4; idx_sel = 2'd1; yk = 4'h5; iy = 16'h0010; operand = 24'h00FFE0; step();
    // R6 wrap at 2^20 via Z
    mode = 4'd5; idx_sel = 2'd2; zk = 4'hF; iz = 16'hFFFF; operand = 24'h000001; step();
    // R7 negative accumulator
    mode = 4'd6; idx_sel = 2'd0; xk = 4'h1; ix = 16'h0000; acc_e = 16'h8000; step();
    // R8 taken short branch backward across bank
    mode = 4'd7; pk = 4'h2; pc = 16'h0000; operand = 24'h0000FE; br_taken = 1'b1; step();
    // R8 untaken word branch
    mode = 4'd8; br_taken = 1'b0; operand = 24'h001000; step();
    // R9 post-modify with strobe, negative step crossing bank
    mode = 4'd9; xk = 4'h1; ix = 16'h0040; operand = 24'h000080; wb_strobe = 1'b1; step();
    // R10 post-modify without strobe keeps pair
    wb_strobe = 1'b0; ix = 16'h1234; operand = 24'h000005; step();
    // R10 strobe in other mode
    mode = 4'd1; wb_strobe = 1'b1; step();
    wb_strobe = 1'b0;
    // R11 illegal select
    mode = 4'd4; idx_sel = 2'd3; step();
    // R12 inherent and reserved
    mode = 4'd0; idx_sel = 2'd0; step();
    mode = 4'd13; step();

    for (int n = 0; n < 3000; n++) begin
      mode = 4'($urandom_range(0, 15));
      idx_sel = 2'($urandom);
      operand = 24'($urandom);
      ix = 16'($urandom); iy = 16'($urandom); iz = 16'($urandom);
      xk = 4'($urandom); yk = 4'($urandom); zk = 4'($urandom); ek = 4'($urandom);
      acc_e = 16'($urandom); pc = 16'($urandom); pk = 4'($urandom);
      br_taken = 1'($urandom); wb_strobe = 1'($urandom);
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule